// File: doc/BRIEF.md
# Port-Write Message Register Interface

This block is the register front end for outbound and inbound port-write maintenance messages. A host on a 32-bit register bus first fills a sixteen-word payload buffer, then writes one control word that carries the destination ID and a packet-ready flag. That single write starts a transmit request toward the link layer. The request presents the buffered payload and the destination on a parallel interface until the link accepts it. While a request is outstanding, the buffer and the destination are frozen.

On the receive side, a software-controlled enable decides whether incoming port-writes are kept. A kept message latches its leading word into a readable register and raises a packet-stored status bit. Status bits live in two groups, a maintenance group and an I/O group. Each group has its own enable mask. The interrupt output is the OR of the enabled pending bits of both groups. Status bits are cleared by writing ones to them.

Register byte offsets are fixed: control at 0x10200, payload at 0x10210 to 0x1024C, receive enable at 0x10250, received word at 0x10254, maintenance status and enable at 0x10080 and 0x10084, I/O status and enable at 0x10088 and 0x1008C.

Top module: `pw_msg_regs`

## Requirements
- R1: After reset, tx_req and irq are 0 and every mapped register reads 0.
- R2: Payload word k (k = 0..15) at byte offset 0x10210 + 4k reads back the last value written to it. It appears on tx_payload bits [32k+31:32k].
- R3: A control write at 0x10200 while idle loads the destination from wdata bits [16+DEST_W-1:16] and the ready flag from bit 0. A ready flag of 1 raises tx_req after the next clock edge. Control reads return the destination zero-extended in bits [31:16] and the ready flag in bit 0.
- R4: tx_req stays high with a stable tx_dest and tx_payload until tx_ack is sampled high. After that edge, tx_req falls and the ready flag reads 0.
- R5: While the ready flag is set, writes to the payload buffer and to the control register have no effect.
- R6: Bit 0 of the register at 0x10250 enables reception. An rx_valid pulse while reception is enabled stores rx_word at 0x10254 and sets maintenance status bit 4 (0x10080). While reception is disabled, the pulse is dropped and changes neither register.
- R7: Writing 1 to a status bit clears it. If a source sets a bit in the same cycle that the bit is cleared, the bit stays set.
- R8: A transmit acceptance (tx_req and tx_ack both high) sets I/O status bit 0 (0x10088).
- R9: irq is high exactly when some status bit is set whose enable bit is also set. The maintenance enables are at 0x10084 and the I/O enables at 0x1008C.
- R10: With DEST_W = 8, destination bits above bit 7 are discarded, and they read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_req | output | 1 | Port-write transmit request |
| tx_ack | input | 1 | Link accepts the request |
| tx_dest | output | DEST_W | Destination ID of the request |
| tx_payload | output | 32*PAY_WORDS | Payload, word k in bits [32k+31:32k] |
| rx_valid | input | 1 | Incoming port-write pulse |
| rx_word | input | 32 | Leading word of the incoming port-write |
| irq | output | 1 | Combined interrupt |

## Verification
The payload buffer is loaded with two different word patterns. The first pattern is distinct per word, which exposes swapped or aliased indices. The second alternates all-ones and all-zeros words, which exposes stuck bits and bit-order errors on the flat bus. The transmit path is tested two ways. A held request with no acknowledge is probed with payload and control writes, which separates a correct freeze from a leaky one. A control write with the ready flag at 0 shows that destination loading is independent of starting a request. Receive pulses arrive with reception disabled, with it enabled, and in the same cycle as a write-one-to-clear. These cases separate the enable gate, the capture, and the set-over-clear priority.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int WORD_W        = 32;
  localparam int RX_STORED_BIT = 4;
  localparam int TX_DONE_BIT   = 0;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PAY,
    SEL_RXEN,
    SEL_RXWORD,
    SEL_MST,
    SEL_MIE,
    SEL_IST,
    SEL_IIE
  } reg_sel_e;
endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/pw_payload_buf.sv
module pw_payload_buf #(
  parameter int WORDS = 16,
  parameter int W     = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [W-1:0]       wr_data,
  output logic [W*WORDS-1:0] words
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [W-1:0] word_q, word_d;
    logic         word_ce;

    assign word_ce = wr_en && (wr_idx == IDX_W'(k));

    always_comb begin
      word_d = word_q;
      if (word_ce) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign words[k*W +: W] = word_q;
  end
endmodule

// File: rtl/pw_irq_group.sv
module pw_irq_group #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         status_wr,
  input  logic         enable_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         pending
);
  logic [W-1:0] status_d, enable_d, clr_vec;

  always_comb begin
    clr_vec  = status_wr ? wdata : '0;
    status_d = (status & ~clr_vec) | set_vec;
    enable_d = enable_wr ? wdata : enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_d;
      enable <= enable_d;
    end
  end

  assign pending = |(status & enable);
endmodule

// File: rtl/pw_msg_regs.sv
module pw_msg_regs
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DEST_W     = 8,
  parameter int PAY_WORDS  = 16,
  parameter int CTRL_OFS   = 'h10200,
  parameter int PAY_OFS    = 'h10210,
  parameter int RXEN_OFS   = 'h10250,
  parameter int RXWORD_OFS = 'h10254,
  parameter int MST_OFS    = 'h10080,
  parameter int MIE_OFS    = 'h10084,
  parameter int IST_OFS    = 'h10088,
  parameter int IIE_OFS    = 'h1008C
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic                        tx_req,
  input  logic                        tx_ack,
  output logic [DEST_W-1:0]           tx_dest,
  output logic [WORD_W*PAY_WORDS-1:0] tx_payload,
  input  logic                        rx_valid,
  input  logic [WORD_W-1:0]           rx_word,
  output logic                        irq
);
  localparam int IDX_W    = $clog2(PAY_WORDS);
  localparam int PAY_SPAN = PAY_WORDS * (WORD_W / 8);
  localparam logic [ADDR_W-1:0] A_MASK = ~ADDR_W'(3);

  logic              rst_sn;
  reg_sel_e          sel;
  logic [ADDR_W-1:0] waddr, pay_off;
  logic [IDX_W-1:0]  pay_idx;

  logic              ready_q, ready_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              rx_en_q, rx_en_d;
  logic [WORD_W-1:0] rx_word_q, rx_word_d;
  logic              accept, store, pay_we;
  logic [WORD_W-1:0] mnt_set, io_set;
  logic [WORD_W-1:0] mnt_status, mnt_en, io_status, io_en;
  logic              mnt_pend, io_pend;

  pw_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_sn(rst_sn));

  // address decode
  always_comb begin
    waddr   = bus_addr & A_MASK;
    pay_off = waddr - ADDR_W'(PAY_OFS);
    pay_idx = pay_off[IDX_W+1:2];
    sel     = SEL_NONE;
    if      (waddr == ADDR_W'(CTRL_OFS))   sel = SEL_CTRL;
    else if (pay_off < ADDR_W'(PAY_SPAN))  sel = SEL_PAY;
    else if (waddr == ADDR_W'(RXEN_OFS))   sel = SEL_RXEN;
    else if (waddr == ADDR_W'(RXWORD_OFS)) sel = SEL_RXWORD;
    else if (waddr == ADDR_W'(MST_OFS))    sel = SEL_MST;
    else if (waddr == ADDR_W'(MIE_OFS))    sel = SEL_MIE;
    else if (waddr == ADDR_W'(IST_OFS))    sel = SEL_IST;
    else if (waddr == ADDR_W'(IIE_OFS))    sel = SEL_IIE;
  end

  assign accept = ready_q && tx_ack;
  assign store  = rx_valid && rx_en_q;
  assign pay_we = bus_wr && (sel == SEL_PAY) && !ready_q;

  // next state: transmit control and receive capture
  always_comb begin
    ready_d   = ready_q;
    dest_d    = dest_q;
    rx_en_d   = rx_en_q;
    rx_word_d = rx_word_q;
    if (accept) begin
      ready_d = 1'b0;
    end else if (!ready_q && bus_wr && sel == SEL_CTRL) begin
      dest_d  = bus_wdata[16 +: DEST_W];
      ready_d = bus_wdata[0];
    end
    if (bus_wr && sel == SEL_RXEN) rx_en_d = bus_wdata[0];
    if (store) rx_word_d = rx_word;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ready_q   <= 1'b0;
      dest_q    <= '0;
      rx_en_q   <= 1'b0;
      rx_word_q <= '0;
    end else begin
      ready_q   <= ready_d;
      dest_q    <= dest_d;
      rx_en_q   <= rx_en_d;
      rx_word_q <= rx_word_d;
    end
  end

  pw_payload_buf #(.WORDS(PAY_WORDS), .W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_sn), .wr_en(pay_we), .wr_idx(pay_idx),
    .wr_data(bus_wdata), .words(tx_payload)
  );

  always_comb begin
    mnt_set = '0;
    mnt_set[RX_STORED_BIT] = store;
    io_set  = '0;
    io_set[TX_DONE_BIT] = accept;
  end

  pw_irq_group #(.W(WORD_W)) u_mnt (
    .clk(clk), .rst_n(rst_sn), .set_vec(mnt_set),
    .status_wr(bus_wr && sel == SEL_MST), .enable_wr(bus_wr && sel == SEL_MIE),
    .wdata(bus_wdata), .status(mnt_status), .enable(mnt_en), .pending(mnt_pend)
  );

  pw_irq_group #(.W(WORD_W)) u_io (
    .clk(clk), .rst_n(rst_sn), .set_vec(io_set),
    .status_wr(bus_wr && sel == SEL_IST), .enable_wr(bus_wr && sel == SEL_IIE),
    .wdata(bus_wdata), .status(io_status), .enable(io_en), .pending(io_pend)
  );

  // read mux
  always_comb begin
    case (sel)
      SEL_CTRL:   bus_rdata = {16'(dest_q), 15'd0, ready_q};
      SEL_PAY:    bus_rdata = tx_payload[int'(pay_idx)*WORD_W +: WORD_W];
      SEL_RXEN:   bus_rdata = {31'd0, rx_en_q};
      SEL_RXWORD: bus_rdata = rx_word_q;
      SEL_MST:    bus_rdata = mnt_status;
      SEL_MIE:    bus_rdata = mnt_en;
      SEL_IST:    bus_rdata = io_status;
      SEL_IIE:    bus_rdata = io_en;
      default:    bus_rdata = '0;
    endcase
  end

  assign tx_req  = ready_q;
  assign tx_dest = dest_q;
  assign irq     = mnt_pend || io_pend;
endmodule

// File: rtl/pw_msg_regs_chk.sv
module pw_msg_regs_chk #(
  parameter int DEST_W    = 8,
  parameter int PAY_WORDS = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tx_req,
  input logic                    tx_ack,
  input logic [DEST_W-1:0]       tx_dest,
  input logic [32*PAY_WORDS-1:0] tx_payload,
  input logic                    rx_valid,
  input logic                    rx_en,
  input logic [31:0]             rx_word_q,
  input logic [31:0]             mnt_status,
  input logic [31:0]             mnt_en,
  input logic [31:0]             io_status,
  input logic [31:0]             io_en,
  input logic                    irq
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req && $stable(tx_dest) && $stable(tx_payload));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack |=> !tx_req);

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack |=> io_status[0]);

  assert_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_en |=> mnt_status[4]);

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_en |=> $stable(rx_word_q) && !$rose(mnt_status[4]));

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_en == 32'd0) && (io_en == 32'd0) |-> !irq);
endmodule

bind pw_msg_regs pw_msg_regs_chk #(.DEST_W(DEST_W), .PAY_WORDS(PAY_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_sn), .tx_req(tx_req), .tx_ack(tx_ack), .tx_dest(tx_dest),
  .tx_payload(tx_payload), .rx_valid(rx_valid), .rx_en(rx_en_q), .rx_word_q(rx_word_q),
  .mnt_status(mnt_status), .mnt_en(mnt_en), .io_status(io_status), .io_en(io_en),
  .irq(irq)
);

// File: tb/pw_msg_regs_test.sv
module pw_msg_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DEST_W = 8;
  localparam int PW     = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 20'h10200, A_PAY = 20'h10210,
    A_RXEN = 20'h10250, A_RXW = 20'h10254, A_MST = 20'h10080, A_MIE = 20'h10084,
    A_IST = 20'h10088, A_IIE = 20'h1008C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, tx_ack = 1'b0, rx_valid = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rx_word = '0, bus_rdata;
  logic tx_req, irq;
  logic [DEST_W-1:0] tx_dest;
  logic [32*PW-1:0] tx_payload;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_msg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req), .tx_ack(tx_ack),
    .tx_dest(tx_dest), .tx_payload(tx_payload), .rx_valid(rx_valid),
    .rx_word(rx_word), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'hC0DE0000 ^ (32'(k) * 32'h00010003);
  endfunction

  task automatic t_reset_r1();
    logic [31:0] d;
    check("R1 tx_req", 32'(tx_req), 0);
    check("R1 irq", 32'(irq), 0);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_PAY + 20'd60, d); check("R1 payload", d, 0);
    rd(A_MST, d); check("R1 mnt status", d, 0);
    rd(A_RXEN, d); check("R1 rx enable", d, 0);
  endtask

  task automatic t_payload_r2();
    logic [31:0] d;
    for (int k = 0; k < PW; k++) wr(A_PAY + 20'(4*k), pat(k));
    for (int k = 0; k < PW; k++) begin
      rd(A_PAY + 20'(4*k), d); check("R2 readback distinct", d, pat(k));
      check("R2 tx_payload distinct", tx_payload[32*k +: 32], pat(k));
    end
    for (int k = 0; k < PW; k++) wr(A_PAY + 20'(4*k), (k % 2 == 0) ? 32'hFFFFFFFF : 32'h0);
    for (int k = 0; k < PW; k++) begin
      rd(A_PAY + 20'(4*k), d);
      check("R2 readback alternating", d, (k % 2 == 0) ? 32'hFFFFFFFF : 32'h0);
      check("R2 tx_payload alternating", tx_payload[32*k +: 32],
            (k % 2 == 0) ? 32'hFFFFFFFF : 32'h0);
    end
    for (int k = 0; k < PW; k++) wr(A_PAY + 20'(4*k), pat(k));
  endtask

  task automatic t_ctrl_noready_r3();
    logic [31:0] d;
    wr(A_CTRL, 32'h0077_0000);
    check("R3 no request when ready=0", 32'(tx_req), 0);
    rd(A_CTRL, d); check("R3 dest only", d, 32'h0077_0000);
    wr(A_PAY + 20'd8, 32'h1111_2222);
    rd(A_PAY + 20'd8, d); check("R5 idle write accepted", d, 32'h1111_2222);
    wr(A_PAY + 20'd8, pat(2));
  endtask

  task automatic t_send_r4();
    logic [31:0] d;
    wr(A_CTRL, 32'hAB55_0001);
    check("R3 tx_req raised", 32'(tx_req), 1);
    check("R10 tx_dest truncated", 32'(tx_dest), 32'h55);
    rd(A_CTRL, d); check("R3 R10 ctrl readback", d, 32'h0055_0001);
    wr(A_PAY + 20'd12, 32'h5A5A_5A5A);
    rd(A_PAY + 20'd12, d); check("R5 payload frozen", d, pat(3));
    check("R5 tx_payload frozen", tx_payload[96 +: 32], pat(3));
    wr(A_CTRL, 32'h0012_0001);
    check("R5 dest frozen", 32'(tx_dest), 32'h55);
    repeat (3) @(negedge clk);
    check("R4 request held", 32'(tx_req), 1);
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
    check("R4 request released", 32'(tx_req), 0);
    rd(A_CTRL, d); check("R4 ready cleared", d, 32'h0055_0000);
    rd(A_IST, d); check("R8 tx done status", d, 32'h1);
    check("R9 masked", 32'(irq), 0);
    wr(A_IIE, 32'h1);
    check("R9 io irq", 32'(irq), 1);
    wr(A_IST, 32'h1);
    check("R7 io w1c irq", 32'(irq), 0);
    rd(A_IST, d); check("R7 io status cleared", d, 0);
    wr(A_IIE, 32'h0);
  endtask

  task automatic t_rx_r6();
    logic [31:0] d;
    @(negedge clk); rx_valid = 1'b1; rx_word = 32'h0000_DEAD;
    @(negedge clk); rx_valid = 1'b0;
    rd(A_RXW, d); check("R6 dropped word", d, 0);
    rd(A_MST, d); check("R6 dropped status", d, 0);
    wr(A_RXEN, 32'h1);
    rd(A_RXEN, d); check("R6 enable readback", d, 1);
    wr(A_MIE, 32'h10);
    check("R9 no pending", 32'(irq), 0);
    @(negedge clk); rx_valid = 1'b1; rx_word = 32'hBEEF_0001;
    @(negedge clk); rx_valid = 1'b0;
    check("R6 R9 rx irq", 32'(irq), 1);
    rd(A_RXW, d); check("R6 captured word", d, 32'hBEEF_0001);
    rd(A_MST, d); check("R6 stored status", d, 32'h10);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_MST; bus_wdata = 32'h10;
    rx_valid = 1'b1; rx_word = 32'h0BAD_F00D;
    @(negedge clk); bus_wr = 1'b0; rx_valid = 1'b0;
    rd(A_MST, d); check("R7 set wins over clear", d, 32'h10);
    wr(A_MST, 32'h10);
    rd(A_MST, d); check("R7 mnt cleared", d, 0);
    check("R7 irq after clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_r1();
    t_payload_r2();
    t_ctrl_noready_r3();
    t_send_r4();
    t_rx_r6();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule